// File: doc/BRIEF.md
# Memory-Reference Operation Sequencer

This block carries out the memory-reference operations of a small 16-bit accumulator machine once the effective address has been resolved upstream. Each operation arrives as one start pulse with a 3-bit operation code, a 2-bit accumulator selector, the resolved target address, and the value of the program counter on entry. That entry value already points at the word after the operation. The block holds four 16-bit accumulators and the program counter. It drives a synchronous single-port memory for loads and stores. Increment-and-test and decrement-and-test operations are passed to an external read-modify-write unit, and the block applies the skip that unit reports.

A subroutine call stores its return address in accumulator 3 and does not push it on a stack. A return is an ordinary jump whose target equals accumulator 3. The return address is taken from the program counter in the same clock edge that loads the jump target. A call whose target was computed from accumulator 3 therefore still lands on the old value of accumulator 3.

Top module: `mref_seq`

## Requirements
- R1: After reset, `busy` and `illegal` are 0, `pc_out` is 0 and all four accumulators in `acc_flat` are 0 (accumulator k occupies bits 16k+15 down to 16k).
- R2: Operation code 0 (load) issues one memory read (`mem_req`=1, `mem_we`=0, `mem_addr`=target) in the cycle after the start edge. The selected accumulator holds the returned word after the second edge following the start edge.
- R3: Operation code 1 (store) issues one memory write in the cycle after the start edge, with `mem_addr`=target and `mem_wdata`=the selected accumulator.
- R4: Operation code 2 (jump) sets `pc_out` to the target at the first edge after the start edge.
- R5: Operation code 3 (call) sets accumulator 3 to the entry program counter and `pc_out` to the target in the same edge. A call whose target equals the old accumulator 3 jumps to that old value.
- R6: Operation codes 4 (increment) and 5 (decrement) raise `rmw_req` for one cycle, with `rmw_addr`=target and `rmw_dec`=1 only for code 5. When `rmw_done` arrives, `pc_out` becomes the entry value plus 1 if `rmw_zero` is 1, and stays at the entry value otherwise.
- R7: Codes 6 and 7 are reserved. Starting one sets `illegal` to 1 and leaves `busy`, the program counter and the accumulators unchanged. The next accepted legal start clears `illegal`.
- R8: `busy` rises at the start edge of a legal operation and falls at the edge that makes the final register or memory update. A start received while `busy` is high is ignored.
- R9: No memory request and no read-modify-write request is made while `busy` is low.
- R10: Every accepted legal start loads the program counter with `pc_in`. Loads and stores leave it at that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opcode | input | 3 | Operation code |
| acc_sel | input | 2 | Accumulator selector |
| target | input | 16 | Resolved target address |
| pc_in | input | 16 | Program counter on entry (operation address plus one) |
| busy | output | 1 | Operation in progress |
| illegal | output | 1 | Last start used a reserved code |
| pc_out | output | 16 | Program counter |
| acc_flat | output | 64 | All four accumulators, accumulator 0 in the low bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |
| rmw_req | output | 1 | Read-modify-write request |
| rmw_dec | output | 1 | 1 selects decrement, 0 increment |
| rmw_addr | output | 16 | Read-modify-write address |
| rmw_done | input | 1 | Read-modify-write finished |
| rmw_zero | input | 1 | Updated word is zero (valid with `rmw_done`) |

## Verification
Stores, jumps and calls finish one edge after the start edge. Loads finish two edges after it. Increment and decrement operations finish one edge after `rmw_done`, which the bench's responder returns so that they take three edges in all. For each operation the bench counts the falling-edge samples during which `busy` is high and compares that count with the expected latency. It then checks the program counter, the accumulators and its own memory image at the first falling edge after `busy` drops. This means every result is read after the edge that produces it and before the next operation can disturb it.

// File: rtl/mref_pkg.sv
package mref_pkg;

    parameter int MREF_W    = 16;
    parameter int MREF_ACCS = 4;
    parameter int MREF_SELW = $clog2(MREF_ACCS);
    parameter int LINK_IDX  = 3;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_JUMP  = 3'd2,
        OP_CALL  = 3'd3,
        OP_INCT  = 3'd4,
        OP_DECT  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LD_REQ,
        S_LD_WAIT,
        S_STORE,
        S_XFER,
        S_RMW_REQ,
        S_RMW_WAIT
    } state_e;

    typedef enum logic [1:0] {
        PC_HOLD,
        PC_ENTRY,
        PC_TARGET,
        PC_SKIP
    } pc_op_e;

    typedef struct packed {
        op_e                   op;
        logic [MREF_SELW-1:0]  sel;
        logic [MREF_W-1:0]     target;
    } cmd_t;

    function automatic logic op_legal(input logic [2:0] code);
        return code[2:1] != 2'b11;
    endfunction

    function automatic state_e first_state(input op_e code);
        case (code)
            OP_LOAD:          return S_LD_REQ;
            OP_STORE:         return S_STORE;
            OP_JUMP, OP_CALL: return S_XFER;
            OP_INCT, OP_DECT: return S_RMW_REQ;
            default:          return S_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/mref_accfile.sv
module mref_accfile #(
    parameter int W = 16,
    parameter int N = 4,
    localparam int SW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [SW-1:0]  wsel,
    input  logic [W-1:0]   wdata,
    input  logic [SW-1:0]  rsel,
    output logic [W-1:0]   rdata,
    output logic [W*N-1:0] flat
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wsel == SW'(g)))
                regs[g] <= wdata;
        end
        assign flat[g*W +: W] = regs[g];
    end

    assign rdata = regs[rsel];

endmodule

// File: rtl/mref_pcreg.sv
module mref_pcreg
    import mref_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  pc_op_e       pc_op,
    input  logic [W-1:0] entry,
    input  logic [W-1:0] jump_to,
    output logic [W-1:0] pc_q
);

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else begin
            case (pc_op)
                PC_ENTRY:  pc_q <= entry;
                PC_TARGET: pc_q <= jump_to;
                PC_SKIP:   pc_q <= pc_q + W'(1);
                default:   pc_q <= pc_q;
            endcase
        end
    end

endmodule

// File: rtl/mref_ctrl.sv
module mref_ctrl
    import mref_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [2:0]            opcode,
    input  logic [MREF_SELW-1:0]  acc_sel,
    input  logic [MREF_W-1:0]     target,
    input  logic                  rmw_done,
    input  logic                  rmw_zero,
    output cmd_t                  cmd,
    output logic                  busy,
    output logic                  illegal,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic                  rmw_req,
    output logic                  rmw_dec,
    output logic                  acc_we,
    output logic [MREF_SELW-1:0]  acc_wsel,
    output logic                  acc_from_link,
    output pc_op_e                pc_op
);

    state_e state;
    logic   accept;

    assign accept = (state == S_IDLE) && start && op_legal(opcode);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cmd     <= '0;
            illegal <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (op_legal(opcode)) begin
                            cmd     <= '{op: op_e'(opcode), sel: acc_sel, target: target};
                            illegal <= 1'b0;
                            state   <= first_state(op_e'(opcode));
                        end else begin
                            illegal <= 1'b1;
                        end
                    end
                end
                S_LD_REQ:   state <= S_LD_WAIT;
                S_LD_WAIT:  state <= S_IDLE;
                S_STORE:    state <= S_IDLE;
                S_XFER:     state <= S_IDLE;
                S_RMW_REQ:  state <= S_RMW_WAIT;
                S_RMW_WAIT: if (rmw_done) state <= S_IDLE;
                default:    state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy          = (state != S_IDLE);
        mem_req       = (state == S_LD_REQ) || (state == S_STORE);
        mem_we        = (state == S_STORE);
        rmw_req       = (state == S_RMW_REQ);
        rmw_dec       = (cmd.op == OP_DECT);
        acc_we        = 1'b0;
        acc_wsel      = cmd.sel;
        acc_from_link = 1'b0;
        pc_op         = PC_HOLD;
        if (accept)
            pc_op = PC_ENTRY;
        case (state)
            S_LD_WAIT: acc_we = 1'b1;
            S_XFER: begin
                pc_op = PC_TARGET;
                if (cmd.op == OP_CALL) begin
                    acc_we        = 1'b1;
                    acc_wsel      = MREF_SELW'(LINK_IDX);
                    acc_from_link = 1'b1;
                end
            end
            S_RMW_WAIT: if (rmw_done && rmw_zero) pc_op = PC_SKIP;
            default: ;
        endcase
    end

endmodule

// File: rtl/mref_seq.sv
module mref_seq
    import mref_pkg::*;
#(
    parameter int W  = MREF_W,
    parameter int NA = MREF_ACCS,
    localparam int SW = $clog2(NA)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      opcode,
    input  logic [SW-1:0]   acc_sel,
    input  logic [W-1:0]    target,
    input  logic [W-1:0]    pc_in,
    output logic            busy,
    output logic            illegal,
    output logic [W-1:0]    pc_out,
    output logic [W*NA-1:0] acc_flat,
    output logic            mem_req,
    output logic            mem_we,
    output logic [W-1:0]    mem_addr,
    output logic [W-1:0]    mem_wdata,
    input  logic [W-1:0]    mem_rdata,
    output logic            rmw_req,
    output logic            rmw_dec,
    output logic [W-1:0]    rmw_addr,
    input  logic            rmw_done,
    input  logic            rmw_zero
);

    cmd_t            cmd;
    logic            acc_we;
    logic [SW-1:0]   acc_wsel;
    logic            acc_from_link;
    logic [W-1:0]    acc_wdata;
    logic [W-1:0]    acc_rdata;
    pc_op_e          pc_op;

    mref_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .opcode        (opcode),
        .acc_sel       (acc_sel),
        .target        (target),
        .rmw_done      (rmw_done),
        .rmw_zero      (rmw_zero),
        .cmd           (cmd),
        .busy          (busy),
        .illegal       (illegal),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .rmw_req       (rmw_req),
        .rmw_dec       (rmw_dec),
        .acc_we        (acc_we),
        .acc_wsel      (acc_wsel),
        .acc_from_link (acc_from_link),
        .pc_op         (pc_op)
    );

    // the link value is the program counter before this edge's update
    assign acc_wdata = acc_from_link ? pc_out : mem_rdata;

    mref_accfile #(.W(W), .N(NA)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .we    (acc_we),
        .wsel  (acc_wsel),
        .wdata (acc_wdata),
        .rsel  (cmd.sel),
        .rdata (acc_rdata),
        .flat  (acc_flat)
    );

    mref_pcreg #(.W(W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .pc_op   (pc_op),
        .entry   (pc_in),
        .jump_to (cmd.target),
        .pc_q    (pc_out)
    );

    assign mem_addr  = cmd.target;
    assign mem_wdata = acc_rdata;
    assign rmw_addr  = cmd.target;

endmodule

// File: rtl/mref_seq_chk.sv
module mref_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [2:0]  opcode,
    input logic [15:0] target,
    input logic [15:0] pc_in,
    input logic        busy,
    input logic        illegal,
    input logic [15:0] pc_out,
    input logic [63:0] acc_flat,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        rmw_req,
    input logic        rmw_dec,
    input logic [15:0] rmw_addr,
    input logic        rmw_done,
    input logic        rmw_zero
);

    logic go;
    assign go = start && !busy;

    p_load_read_r2: assert property (@(posedge clk) disable iff (rst)
        go && opcode == 3'd0 |=> mem_req && !mem_we && mem_addr == $past(target));

    p_store_write_r3: assert property (@(posedge clk) disable iff (rst)
        go && opcode == 3'd1 |=> mem_req && mem_we && mem_addr == $past(target));

    p_jump_pc_r4: assert property (@(posedge clk) disable iff (rst)
        go && opcode == 3'd2 |=> ##1 pc_out == $past(target, 2));

    p_call_link_r5: assert property (@(posedge clk) disable iff (rst)
        go && opcode == 3'd3 |=> ##1 acc_flat[63:48] == $past(pc_in, 2)
                                     && pc_out == $past(target, 2));

    p_rmw_issue_r6: assert property (@(posedge clk) disable iff (rst)
        go && (opcode == 3'd4 || opcode == 3'd5) |=>
            rmw_req && rmw_addr == $past(target) && rmw_dec == ($past(opcode) == 3'd5));

    p_rmw_skip_r6: assert property (@(posedge clk) disable iff (rst)
        busy && rmw_done && !rmw_req |=>
            !busy && pc_out == $past(pc_out) + 16'($past(rmw_zero)));

    p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        go && opcode[2:1] == 2'b11 |=> illegal && !busy && $stable(pc_out));

    p_busy_rise_r8: assert property (@(posedge clk) disable iff (rst)
        go && opcode[2:1] != 2'b11 |=> busy && !illegal && pc_out == $past(pc_in));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !rmw_req);

endmodule

bind mref_seq mref_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opcode   (opcode),
    .target   (target),
    .pc_in    (pc_in),
    .busy     (busy),
    .illegal  (illegal),
    .pc_out   (pc_out),
    .acc_flat (acc_flat),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rmw_req  (rmw_req),
    .rmw_dec  (rmw_dec),
    .rmw_addr (rmw_addr),
    .rmw_done (rmw_done),
    .rmw_zero (rmw_zero)
);

// File: tb/mref_seq_test.sv
`timescale 1ns/1ps
module mref_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [1:0]  acc_sel = '0;
    logic [15:0] target = '0;
    logic [15:0] pc_in = '0;
    logic        busy, illegal;
    logic [15:0] pc_out;
    logic [63:0] acc_flat;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        rmw_req, rmw_dec;
    logic [15:0] rmw_addr;
    logic        rmw_done = 1'b0;
    logic        rmw_zero = 1'b0;

    int applied = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    mref_seq uut (.*);

    // memory image and read-modify-write responder
    logic [15:0] mem [256];
    logic        rmw_s1 = 1'b0;
    logic [7:0]  rmw_a = '0;
    logic        rmw_d = 1'b0;

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
        rmw_s1   <= rmw_req;
        rmw_done <= 1'b0;
        if (rmw_req) begin
            rmw_a <= rmw_addr[7:0];
            rmw_d <= rmw_dec;
        end
        if (rmw_s1) begin
            logic [15:0] nv;
            nv = rmw_d ? mem[rmw_a] - 16'd1 : mem[rmw_a] + 16'd1;
            mem[rmw_a] <= nv;
            rmw_zero   <= (nv == 16'd0);
            rmw_done   <= 1'b1;
        end
    end

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sel;
        logic [15:0] tgt;
        logic [15:0] pc;
        logic [15:0] xpc;
        logic [15:0] xval;
    } vec_t;

    localparam int NV = 15;
    // xval: load -> acc[sel]; store, inc, dec -> mem[tgt]; jump, call -> acc3
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd0, 16'h0010, 16'h0100, 16'h0100, 16'h1234},
        '{3'd0, 2'd1, 16'h0011, 16'h0101, 16'h0101, 16'hABCD},
        '{3'd1, 2'd1, 16'h0030, 16'h0102, 16'h0102, 16'hABCD},
        '{3'd1, 2'd0, 16'h0031, 16'h0103, 16'h0103, 16'h1234},
        '{3'd2, 2'd0, 16'h0200, 16'h0104, 16'h0200, 16'h0000},
        '{3'd3, 2'd0, 16'h0300, 16'h0201, 16'h0300, 16'h0201},
        '{3'd2, 2'd0, 16'h0201, 16'h0301, 16'h0201, 16'h0201},
        '{3'd4, 2'd0, 16'h0020, 16'h0202, 16'h0202, 16'h0002},
        '{3'd4, 2'd0, 16'h0021, 16'h0203, 16'h0204, 16'h0000},
        '{3'd5, 2'd0, 16'h0022, 16'h0205, 16'h0206, 16'h0000},
        '{3'd5, 2'd0, 16'h0023, 16'h0207, 16'h0207, 16'h0004},
        '{3'd0, 2'd3, 16'h0031, 16'h0208, 16'h0208, 16'h1234},
        '{3'd3, 2'd0, 16'h1234, 16'h0209, 16'h1234, 16'h0209},
        '{3'd0, 2'd2, 16'h0030, 16'h020A, 16'h020A, 16'hABCD},
        '{3'd1, 2'd3, 16'h0032, 16'h020B, 16'h020B, 16'h0209}
    };

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int lat_of(input logic [2:0] op);
        case (op)
            3'd0: return 2;
            3'd4, 3'd5: return 3;
            default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] acc_of(input int k);
        return acc_flat[k*16 +: 16];
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [1:0] sel,
                          input logic [15:0] tgt, input logic [15:0] pc, output int lat);
        @(negedge clk);
        start = 1'b1; opcode = op; acc_sel = sel; target = tgt; pc_in = pc;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (busy && lat < 100) begin
            lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            applied++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        for (int i = 0; i < 256; i++) mem[i] = 16'h5A00 + 16'(i);
        mem[8'h10] = 16'h1234;
        mem[8'h11] = 16'hABCD;
        mem[8'h20] = 16'h0001;
        mem[8'h21] = 16'hFFFF;
        mem[8'h22] = 16'h0001;
        mem[8'h23] = 16'h0005;
        mem[8'h24] = 16'h0000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", 32'(busy), 0);
        check(illegal == 1'b0, "R1", "illegal", 32'(illegal), 0);
        check(pc_out == 16'h0, "R1", "pc", 32'(pc_out), 0);
        check(acc_flat == 64'h0, "R1", "accs", acc_flat[31:0] | acc_flat[63:32], 0);
        // R9 idle: no requests
        check(!mem_req && !rmw_req, "R9", "idle requests",
              32'({mem_req, rmw_req}), 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [15:0] got;
            v = VEC[i];
            run_op(v.op, v.sel, v.tgt, v.pc, lat);
            check(lat == lat_of(v.op), "R8", "busy cycles", 32'(lat), 32'(lat_of(v.op)));
            check(pc_out == v.xpc, (v.op <= 3'd1) ? "R10" : req_of(v.op), "pc",
                  32'(pc_out), 32'(v.xpc));
            case (v.op)
                3'd0:       got = acc_of(int'(v.sel));
                3'd2, 3'd3: got = acc_of(3);
                default:    got = mem[v.tgt[7:0]];
            endcase
            check(got == v.xval, req_of(v.op), "value", 32'(got), 32'(v.xval));
        end

        // R6 decrement wraps 0 -> FFFF, no skip
        run_op(3'd5, 2'd0, 16'h0024, 16'h0400, lat);
        check(mem[8'h24] == 16'hFFFF, "R6", "dec wrap value", 32'(mem[8'h24]), 32'hFFFF);
        check(pc_out == 16'h0400, "R6", "no skip on nonzero", 32'(pc_out), 32'h0400);

        // R7 reserved codes
        run_op(3'd6, 2'd1, 16'h0777, 16'h0555, lat);
        check(lat == 0, "R7", "no busy", 32'(lat), 0);
        check(illegal == 1'b1, "R7", "flag set", 32'(illegal), 1);
        check(pc_out == 16'h0400, "R7", "pc untouched", 32'(pc_out), 32'h0400);
        run_op(3'd7, 2'd1, 16'h0010, 16'h0556, lat);
        check(acc_of(1) == 16'hABCD, "R7", "acc untouched", 32'(acc_of(1)), 32'hABCD);
        run_op(3'd2, 2'd0, 16'h0600, 16'h0401, lat);
        check(illegal == 1'b0, "R7", "flag cleared", 32'(illegal), 0);
        check(pc_out == 16'h0600, "R4", "jump after reserved", 32'(pc_out), 32'h0600);

        // R8 start while busy is ignored
        @(negedge clk);
        start = 1'b1; opcode = 3'd0; acc_sel = 2'd2; target = 16'h0010; pc_in = 16'h0700;
        @(negedge clk);
        check(busy == 1'b1, "R8", "busy after start", 32'(busy), 1);
        opcode = 3'd2; target = 16'h0999; pc_in = 16'h0888;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R8", "second start dropped", 32'(busy), 0);
        check(pc_out == 16'h0700, "R8", "pc after ignored start", 32'(pc_out), 32'h0700);
        check(acc_of(2) == 16'h1234, "R2", "load during ignore", 32'(acc_of(2)), 32'h1234);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule